// File: doc/BRIEF.md
# Counter overflow flag register with interrupt

This block keeps one sticky overflow flag per performance counter and drives a single interrupt line toward an interrupt controller. Software changes the flags through a write-one-to-set port and a write-one-to-clear port. Each port answers at two addresses that act the same way. Counter hardware raises flags directly with one-cycle overflow pulses. A separate enable mask decides whether a new interrupt is raised.

The interrupt line is not a masked OR of the flags. It is re-evaluated only when the whole flag word crosses between zero and nonzero:
- On the crossing to nonzero, it asserts only if some new flag is also enabled.
- On the crossing to zero, it drops.
- While the word stays nonzero it holds its value, whatever happens to individual flags or to the mask.

Register access is a simple strobe interface. A write takes effect on the next clock edge. Reads are combinational and have no side effects.

Top module: `ovf_status_irq`

## Requirements
- R1: After reset (rst_ni low), the flag word, the enable mask and irq_o are all zero.
- R2: A write to address 0 or address 1 ORs wr_data_i into the flag word. Both addresses behave identically.
- R3: A write to address 2 or address 3 clears every flag whose wr_data_i bit is one and leaves the others unchanged. Both addresses behave identically.
- R4: A read at addresses 0 to 3 returns the current flag word. A read at address 4 returns the enable mask. Reads change no state.
- R5: A one on hw_ovf_i[i] in a cycle sets flag i at the following clock edge.
- R6: If a software clear and a hardware pulse hit the same bit in the same cycle, the bit ends up set.
- R7: When the flag word goes from zero to nonzero, irq_o becomes one if (new flags AND the mask held before that edge) is nonzero, and zero otherwise.
- R8: When the flag word goes from nonzero to zero, irq_o becomes zero. irq_o is never one while the flag word is zero.
- R9: When the flag word is nonzero both before and after an edge, irq_o keeps its previous value.
- R10: A write to address 4 replaces the enable mask and changes neither the flags nor irq_o.
- R11: Writes to addresses 5 to 7 have no effect, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Read data, combinational |
| hw_ovf_i | input | 32 | Per-counter overflow pulses |
| irq_o | output | 1 | Overflow interrupt |

## Verification
A stale or wrong flag word shows up one edge after the causing write or pulse, as a wrong read value at addresses 0 to 3. Because the interrupt keeps history, a wrong irq state is the dangerous case. Once the flag word is nonzero, such an error persists at irq_o until the word next returns to zero. For that reason the sequences hold the word nonzero across mask changes and partial clears, and then check irq_o at every step. The same-cycle clear-versus-pulse collision and the alias addresses are each driven one edge at a time.

// File: rtl/ovf_pkg.sv
package ovf_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_SET0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_SET1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLR0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_CLR1 = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd4;
endpackage

// File: rtl/ovf_reg_decode.sv
module ovf_reg_decode
  import ovf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [DW-1:0]     set_bits_o,
  output logic [DW-1:0]     clr_bits_o,
  output logic              mask_we_o
);
  localparam int NALIAS = 2;
  localparam logic [NALIAS*ADDR_W-1:0] SET_ADDRS = {A_SET1, A_SET0};
  localparam logic [NALIAS*ADDR_W-1:0] CLR_ADDRS = {A_CLR1, A_CLR0};

  logic [NALIAS-1:0] set_hit, clr_hit;

  for (genvar a = 0; a < NALIAS; a++) begin : g_alias
    assign set_hit[a] = wr_addr_i == SET_ADDRS[a*ADDR_W +: ADDR_W];
    assign clr_hit[a] = wr_addr_i == CLR_ADDRS[a*ADDR_W +: ADDR_W];
  end

  assign set_bits_o = (wr_en_i && |set_hit) ? wr_data_i : '0;
  assign clr_bits_o = (wr_en_i && |clr_hit) ? wr_data_i : '0;
  assign mask_we_o  = wr_en_i && (wr_addr_i == A_MASK);
endmodule

// File: rtl/ovf_status_reg.sv
module ovf_status_reg #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_bits_i,
  input  logic [N-1:0] clr_bits_i,
  input  logic [N-1:0] hw_ovf_i,
  output logic [N-1:0] stat_q_o,
  output logic [N-1:0] stat_nxt_o
);
  logic [N-1:0] stat_q;

  // hardware pulse wins over a same-cycle software clear
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign stat_nxt_o[i] = hw_ovf_i[i] | ((stat_q[i] | set_bits_i[i]) & ~clr_bits_i[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_nxt_o;
  end

  assign stat_q_o = stat_q;

  AST_HW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_ovf_i) |=> ((stat_q & $past(hw_ovf_i)) == $past(hw_ovf_i))); // R5
  AST_CLR_WINS_LOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_bits_i) |=> ((stat_q & $past(clr_bits_i & ~hw_ovf_i)) == '0)); // R6
  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_bits_i) |=> ((stat_q & $past(set_bits_i)) == $past(set_bits_i))); // R2
endmodule

// File: rtl/ovf_irq_ctrl.sv
module ovf_irq_ctrl #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] stat_q_i,
  input  logic [N-1:0] stat_nxt_i,
  input  logic [N-1:0] mask_q_i,
  output logic         irq_o
);
  logic irq_q, irq_d;
  logic was_set, will_set;

  assign was_set  = |stat_q_i;
  assign will_set = |stat_nxt_i;

  always_comb begin
    irq_d = irq_q;
    if (was_set && !will_set)      irq_d = 1'b0;
    else if (!was_set && will_set) irq_d = |(stat_nxt_i & mask_q_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stat_q_i) == '0 && stat_q_i != '0) |-> (irq_o == |(stat_q_i & $past(mask_q_i)))); // R7
  AST_IRQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q_i == '0) |-> !irq_o); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stat_q_i) != '0 && stat_q_i != '0) |-> (irq_o == $past(irq_o))); // R9
endmodule

// File: rtl/ovf_status_irq.sv
module ovf_status_irq
  import ovf_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [N-1:0]      wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [N-1:0]      rd_data_o,
  input  logic [N-1:0]      hw_ovf_i,
  output logic              irq_o
);
  logic [N-1:0] set_bits, clr_bits, stat_q, stat_nxt, mask_q;
  logic         mask_we;

  ovf_reg_decode #(.DW(N)) u_dec (
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .set_bits_o (set_bits),
    .clr_bits_o (clr_bits),
    .mask_we_o  (mask_we)
  );

  ovf_status_reg #(.N(N)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_bits_i (set_bits),
    .clr_bits_i (clr_bits),
    .hw_ovf_i   (hw_ovf_i),
    .stat_q_o   (stat_q),
    .stat_nxt_o (stat_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_we) mask_q <= wr_data_i;
  end

  ovf_irq_ctrl #(.N(N)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stat_q_i   (stat_q),
    .stat_nxt_i (stat_nxt),
    .mask_q_i   (mask_q),
    .irq_o      (irq_o)
  );

  always_comb begin
    unique case (rd_addr_i)
      A_SET0, A_SET1, A_CLR0, A_CLR1: rd_data_o = stat_q;
      A_MASK:                         rd_data_o = mask_q;
      default:                        rd_data_o = '0;
    endcase
  end

  AST_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_we && hw_ovf_i == '0) |=> (stat_q == $past(stat_q) && irq_o == $past(irq_o))); // R10
endmodule

// File: tb/sim_ovf_status_irq.sv
module sim_ovf_status_irq;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  typedef struct {
    logic [N-1:0] rd;
    logic         irq;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [N-1:0] rd_data;
  logic [N-1:0] hw_ovf = '0;
  logic         irq;

  int n_run = 0, n_fail = 0;
  exp_t sb_q[$];
  logic [N-1:0] m_stat = '0, m_mask = '0;
  logic         m_irq = 1'b0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovf_status_irq #(.N(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .hw_ovf_i(hw_ovf), .irq_o(irq)
  );

  // driver: drive one cycle at negedge, push the expected post-edge result
  task automatic op(input bit we, input logic [2:0] wa, input logic [N-1:0] wd,
                    input logic [N-1:0] hw, input logic [2:0] ra, input string tag);
    logic [N-1:0] nxt;
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; hw_ovf = hw; rd_addr = ra;
    nxt = m_stat;
    if (we && wa <= 3'd1) nxt = nxt | wd;
    if (we && (wa == 3'd2 || wa == 3'd3)) nxt = nxt & ~wd;
    nxt = nxt | hw;
    if (m_stat != '0 && nxt == '0) m_irq = 1'b0;
    else if (m_stat == '0 && nxt != '0) m_irq = |(nxt & m_mask);
    m_stat = nxt;
    if (we && wa == 3'd4) m_mask = wd;
    e.rd  = (ra <= 3'd3) ? m_stat : (ra == 3'd4) ? m_mask : '0;
    e.irq = m_irq;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (rst_ni && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_run++;
      if (rd_data !== e.rd || irq !== e.irq) begin
        n_fail++;
        $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b", e.tag, rd_data, irq, e.rd, e.irq);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_fail++;
        $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (rd_data !== '0 || irq !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 in reset: rd=%h irq=%b expected rd=0 irq=0", rd_data, irq);
    end
    rst_ni = 1'b1;
    op(0, 0, '0, '0, 3'd0, "R1 flags after reset");
    op(0, 0, '0, '0, 3'd4, "R1 mask after reset");
    op(1, 3'd4, 32'h0000_00F0, '0, 3'd4, "R10 mask write, irq unchanged");
    op(1, 3'd0, 32'h1, '0, 3'd0, "R7 R2 set alias0, unmasked bit, no irq");
    op(1, 3'd1, 32'h10, '0, 3'd1, "R9 R2 set alias1 while nonzero, irq held low");
    op(1, 3'd2, 32'h11, '0, 3'd2, "R3 R8 clear alias0 to zero");
    op(1, 3'd1, 32'h20, '0, 3'd0, "R7 R2 set enabled bit raises irq");
    op(1, 3'd0, 32'h3, '0, 3'd0, "R9 extra set keeps irq");
    op(1, 3'd3, 32'h20, '0, 3'd3, "R3 R9 clear alias1 of enabled bit, irq held");
    op(0, 3'd0, '0, '0, 3'd3, "R4 read has no side effect");
    op(1, 3'd4, 32'h0, '0, 3'd0, "R10 mask cleared, irq held");
    op(1, 3'd2, 32'h3, '0, 3'd0, "R8 clear to zero drops irq");
    op(0, 3'd0, '0, 32'h8000_0000, 3'd0, "R5 hw pulse bit31, mask 0, no irq");
    op(1, 3'd4, 32'h8000_0000, '0, 3'd0, "R10 enabling set flag raises nothing");
    op(1, 3'd2, 32'h8000_0000, 32'h8000_0000, 3'd0, "R6 hw beats clear");
    op(1, 3'd3, 32'hFFFF_FFFF, '0, 3'd0, "R3 clear all");
    op(0, 3'd0, '0, 32'h8000_0000, 3'd0, "R5 R7 hw pulse enabled raises irq");
    op(1, 3'd6, 32'hFFFF_FFFF, '0, 3'd0, "R11 write to unmapped ignored");
    op(1, 3'd5, 32'h0, '0, 3'd4, "R11 unmapped write leaves mask");
    op(0, 3'd0, '0, '0, 3'd7, "R11 unmapped read is zero");
    op(1, 3'd2, 32'hFFFF_FFFF, 32'h10, 3'd0, "R6 R9 clear all with pulse, irq held");
    op(1, 3'd2, 32'hFFFF_FFFF, '0, 3'd0, "R8 final clear drops irq");
    op(0, 3'd0, '0, '0, 3'd0, "R8 idle stays low");
    @(negedge clk);
    wr_en = 1'b0; hw_ovf = '0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule